// File: doc/BRIEF.md
# Key-locked system control register file

This block is a bank of 32-bit control and status words on a simple word-addressed bus. The bus decodes a 4 KiB window. A key word at the bottom of the map protects most of the lower map. Until the correct key has been written, writes to offsets 0x04 through 0xFC are dropped. Words from 0x100 upward can always be written.

Several words are read-only, one is write-only, and one returns a fresh pseudo-random word on every read. That random word comes from an on-chip LFSR that steps every clock.

On reset, every word loads a default from a table that a revision parameter selects. The revision word, the two strap words and the key flag are then taken from input pins instead of the table. Each request is a single cycle. Read data and the error pulse appear one cycle after the request.

Top module: `sysctl_keyreg`

## Requirements
- R1: The word index is the byte address shifted right by 2, and the address is 12 bits wide. An access whose two low address bits are not zero is misaligned: it writes nothing, returns zero on a read and raises the error pulse.
- R2: A write to offset 0x00 stores 1 when the data equals the key parameter (default 0x1688A8A8) and 0 for any other data. A read of offset 0x00 returns 0 or 1 only.
- R3: While the key flag is 0, a write to offsets 0x04 through 0xFC leaves the word unchanged and raises the error pulse. Writes at 0x100 and above are accepted whatever the flag is.
- R4: Offsets 0x14, 0x50 through 0x6C, 0x78, 0x7C, 0xE0 and 0xE4 are read-only. A write to any of them changes nothing and raises the error pulse.
- R5: A read of offset 0x78 returns the LFSR state and stores it in that word, whatever the control word at 0x74 holds. The LFSR is a right-shifting Galois register with mask 0x80200003 and steps once per clock. Two reads in consecutive cycles therefore return r1 and then r2, where r2 = (r1>>1) ^ (r1[0] ? 0x80200003 : 0).
- R6: Offset 0xC0 accepts writes. A read of 0xC0 returns the stored value and raises the error pulse in the same response.
- R7: An access at or beyond the last word (byte offset 0x1A8 and up) writes nothing, returns zero on a read and raises the error pulse.
- R8: Reset loads the default table of the selected revision; for revision 0 this gives 0x74 = 0x0000000E, 0x40 = 0x000000C0 and 0x24 = 0x00000291. After reset, offset 0x7C reads the revision pins, 0x70 and 0xD0 read the two strap pins, and the key flag equals the key-open pin.
- R9: Read data and a one-cycle read-valid appear on the cycle after a read request. The error pulse appears on the cycle after the offending request and lasts exactly one cycle.
- R10: With the key flag set, any other in-range word (offsets 0x04 through 0x1A4 that R4 does not name) reads back exactly the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rev_word_i | input | 32 | Revision word loaded at reset |
| strap1_i | input | 32 | First strap word loaded at reset |
| strap2_i | input | 32 | Second strap word loaded at reset |
| key_open_i | input | 1 | Key flag value loaded at reset |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle error indication |

## Verification
A read of the write-only word produces two results in one response: the stored data on the data port and the error pulse. The bench first writes a known pattern to 0xC0 with the key open. It then reads the word and requires both the pattern and a raised error in the same sample. A random-word read also returns the LFSR value on the very edge at which the LFSR steps. Two reads issued back to back are judged by applying one LFSR step arithmetically to the first result and comparing it with the second.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // word indices whose behaviour depends on position
   localparam int IDX_KEY     = 0;
   localparam int IDX_FREQ    = 5;
   localparam int IDX_SCR_LO  = 20;
   localparam int IDX_SCR_HI  = 27;
   localparam int IDX_STRAP1  = 28;
   localparam int IDX_RNG     = 30;
   localparam int IDX_REV     = 31;
   localparam int IDX_WONLY   = 48;
   localparam int IDX_STRAP2  = 52;
   localparam int IDX_CNT_LO  = 56;
   localparam int IDX_CNT_HI  = 57;

   typedef struct packed {
      logic in_range;
      logic misaligned;
      logic is_key;
      logic lock_zone;
      logic read_only;
      logic write_only;
      logic is_rng;
   } acc_class_t;

   // defaults shared by both revisions
   function automatic logic [31:0] common_default(int idx);
      case (idx)
         1:   return 32'hFFCFFEDC;
         2:   return 32'hF3F40000;
         3:   return 32'h19FC3E8B;
         7:   return 32'h00026108;
         8:   return 32'h00030291;
         11:  return 32'h00000010;
         12:  return 32'h20001A03;
         13:  return 32'h20001A03;
         14:  return 32'h04000030;
         15:  return 32'h00000001;
         16:  return 32'h000000C0;
         19:  return 32'h00000023;
         29:  return 32'h0000000E;
         33:  return 32'h0000F000;
         36:  return 32'h0000A000;
         41:  return 32'hFFFF0000;
         42:  return 32'h000FFFFF;
         56:  return 32'h000000FF;
         57:  return 32'h000000FF;
         65:  return 32'h80000000;
         68:  return 32'h1E600000;
         69:  return 32'hC0000000;
         88:  return 32'h00001903;
         96:  return 32'h0000007B;
         105: return 32'h00002402;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] default_rev_a(int idx);
      case (idx)
         9:  return 32'h00000291;
         34: return 32'h01000000;
         35: return 32'h000000FF;
         39: return 32'h003FFFF3;
         default: return common_default(idx);
      endcase
   endfunction

   function automatic logic [31:0] default_rev_b(int idx);
      case (idx)
         9:  return 32'h93000400;
         34: return 32'h03000000;
         35: return 32'h00000000;
         39: return 32'h023FFFF3;
         default: return common_default(idx);
      endcase
   endfunction

endpackage

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr #(
   parameter int          WIDTH = 32,
   parameter logic [31:0] MASK  = 32'h80200003,
   parameter logic [31:0] SEED  = 32'h00000001
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] state_o
);

   initial begin
      assert (WIDTH == 32) else $error("lfsr width must be 32");
      assert (SEED != '0) else $error("lfsr seed must be nonzero");
   end

   logic [WIDTH-1:0] st;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= SEED[WIDTH-1:0];
      else if (st[0]) st <= (st >> 1) ^ MASK[WIDTH-1:0];
      else st <= st >> 1;
   end

   assign state_o = st;

   // R5: a nonzero seed never collapses to the all-zero lockup state
   assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st != '0);

endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NUM_REGS = 106,
   parameter int LOCK_END = 64,
   localparam int IDX_W   = ADDR_W - 2,
   localparam int SLOT_W  = $clog2(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SLOT_W-1:0] slot_o,
   output acc_class_t        cls_o
);

   logic [IDX_W-1:0] idx;

   assign idx    = addr_i[ADDR_W-1:2];
   assign slot_o = idx[SLOT_W-1:0];

   always_comb begin
      cls_o            = '0;
      cls_o.misaligned = (addr_i[1:0] != 2'b00);
      cls_o.in_range   = (idx < IDX_W'(NUM_REGS));
      cls_o.is_key     = (idx == IDX_W'(IDX_KEY));
      cls_o.lock_zone  = (idx > IDX_W'(IDX_KEY)) && (idx < IDX_W'(LOCK_END));
      cls_o.read_only  = (idx == IDX_W'(IDX_FREQ))
                      || ((idx >= IDX_W'(IDX_SCR_LO)) && (idx <= IDX_W'(IDX_SCR_HI)))
                      || (idx == IDX_W'(IDX_RNG))
                      || (idx == IDX_W'(IDX_REV))
                      || (idx == IDX_W'(IDX_CNT_LO))
                      || (idx == IDX_W'(IDX_CNT_HI));
      cls_o.write_only = (idx == IDX_W'(IDX_WONLY));
      cls_o.is_rng     = (idx == IDX_W'(IDX_RNG));
   end

endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
   import sysctl_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 32,
   parameter int          NUM_REGS  = 106,
   parameter int          LOCK_END  = 64,
   parameter logic [31:0] KEY       = 32'h1688A8A8,
   parameter int          REV_SEL   = 0,
   parameter logic [31:0] LFSR_MASK = 32'h80200003,
   parameter logic [31:0] LFSR_SEED = 32'h00000001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] rev_word_i,
   input  logic [DATA_W-1:0] strap1_i,
   input  logic [DATA_W-1:0] strap2_i,
   input  logic              key_open_i,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              err_pulse
);

   localparam int SLOT_W = $clog2(NUM_REGS);

   initial begin
      assert (DATA_W == 32) else $error("word width must be 32");
      assert (NUM_REGS <= (1 << (ADDR_W - 2))) else $error("map exceeds window");
      assert (NUM_REGS > IDX_STRAP2) else $error("map too small for fixed words");
      assert (LOCK_END <= NUM_REGS) else $error("lock zone exceeds map");
      assert (REV_SEL == 0 || REV_SEL == 1) else $error("unknown revision select");
   end

   logic [DATA_W-1:0] regs    [NUM_REGS];
   logic [DATA_W-1:0] rst_tab [NUM_REGS];
   logic [SLOT_W-1:0] slot;
   acc_class_t        cls;
   logic [DATA_W-1:0] rnd;
   logic              key_flag;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_tab
      if (REV_SEL == 0) begin : g_rev_a
         assign rst_tab[g] = default_rev_a(g);
      end else begin : g_rev_b
         assign rst_tab[g] = default_rev_b(g);
      end
   end

   sysctl_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .LOCK_END (LOCK_END)
   ) u_dec (
      .addr_i (req_addr),
      .slot_o (slot),
      .cls_o  (cls)
   );

   sysctl_lfsr #(
      .WIDTH (DATA_W),
      .MASK  (LFSR_MASK),
      .SEED  (LFSR_SEED)
   ) u_rng (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_o (rnd)
   );

   assign key_flag = regs[IDX_KEY][0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_tab[i];
         regs[IDX_KEY]    <= {{(DATA_W-1){1'b0}}, key_open_i};
         regs[IDX_REV]    <= rev_word_i;
         regs[IDX_STRAP1] <= strap1_i;
         regs[IDX_STRAP2] <= strap2_i;
         rsp_valid        <= 1'b0;
         rsp_rdata        <= '0;
         err_pulse        <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         err_pulse <= 1'b0;
         if (req_valid && req_write) begin
            if (!cls.in_range || cls.misaligned) begin
               err_pulse <= 1'b1;
            end else if (cls.is_key) begin
               regs[IDX_KEY] <= {{(DATA_W-1){1'b0}}, (req_wdata == KEY[DATA_W-1:0])};
            end else if (cls.lock_zone && !key_flag) begin
               err_pulse <= 1'b1;
            end else if (cls.read_only) begin
               err_pulse <= 1'b1;
            end else begin
               regs[slot] <= req_wdata;
            end
         end else if (req_valid) begin
            rsp_valid <= 1'b1;
            if (!cls.in_range || cls.misaligned) begin
               rsp_rdata <= '0;
               err_pulse <= 1'b1;
            end else if (cls.is_rng) begin
               rsp_rdata  <= rnd;
               regs[slot] <= rnd;
            end else begin
               rsp_rdata <= regs[slot];
               err_pulse <= cls.write_only;
            end
         end
      end
   end

   // R2: the key word only ever holds a flag
   assert_key_binary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      regs[IDX_KEY][DATA_W-1:1] == '0);

   // R3: a locked write leaves the target word alone and reports
   assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && cls.in_range && !cls.misaligned && cls.lock_zone && !key_flag)
      |=> (regs[$past(slot)] == $past(regs[slot])) && err_pulse);

   // R4: read-only words survive writes
   assert_ro_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && cls.in_range && !cls.misaligned && cls.read_only)
      |=> (regs[$past(slot)] == $past(regs[slot])) && err_pulse);

   // R5: random read returns the generator state seen at the request edge
   assert_rng_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && cls.in_range && !cls.misaligned && cls.is_rng)
      |=> (rsp_rdata == $past(rnd)) && rsp_valid && !err_pulse);

   // R7: out-of-range reads return zero with an error
   assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !cls.in_range)
      |=> (rsp_rdata == '0) && err_pulse);

   // R9: no response without a request one cycle earlier
   assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);

endmodule

// File: tb/sysctl_keyreg_test.sv
module sysctl_keyreg_test;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] KEY_VAL    = 32'h1688A8A8;
   localparam logic [31:0] MASK_VAL   = 32'h80200003;
   localparam int          NREG       = 106;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rev_word_i = 32'h04030303;
   logic [31:0] strap1_i   = 32'hA5A50001;
   logic [31:0] strap2_i   = 32'h5A5A0002;
   logic        key_open_i = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        err_pulse;

   int checks = 0;
   int errors = 0;
   logic [31:0] snap [NREG];

   sysctl_keyreg uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rev_word_i (rev_word_i),
      .strap1_i   (strap1_i),
      .strap2_i   (strap2_i),
      .key_open_i (key_open_i),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .err_pulse  (err_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] lfsr_step(logic [31:0] s);
      return s[0] ? ((s >> 1) ^ MASK_VAL) : (s >> 1);
   endfunction

   function automatic logic [31:0] pat(int idx);
      logic [7:0] b = 8'(idx);
      return {b, ~b, 16'hC35A};
   endfunction

   function automatic bit is_ro(int idx);
      return idx == 5 || (idx >= 20 && idx <= 27) || idx == 30 || idx == 31
          || idx == 56 || idx == 57;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one request, response sampled on the following falling edge
   task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er, output logic rv);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rd = rsp_rdata; er = err_pulse; rv = rsp_valid;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd, r1, r2;
      logic er, rv;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset contents
      xfer(0, 12'h000, 0, rd, er, rv); chk("R8 key flag after reset", rd, 32'h0);
      xfer(0, 12'h070, 0, rd, er, rv); chk("R8 strap1", rd, strap1_i);
      xfer(0, 12'h0D0, 0, rd, er, rv); chk("R8 strap2", rd, strap2_i);
      xfer(0, 12'h07C, 0, rd, er, rv); chk("R8 revision", rd, rev_word_i);
      xfer(0, 12'h074, 0, rd, er, rv); chk("R8 rng control default", rd, 32'h0000000E);
      xfer(0, 12'h040, 0, rd, er, rv); chk("R8 scratch default", rd, 32'h000000C0);
      xfer(0, 12'h024, 0, rd, er, rv); chk("R8 revision-0 table", rd, 32'h00000291);
      // R9: read response timing
      chk("R9 read valid", {31'b0, rv}, 32'h1);
      @(negedge clk);
      chk("R9 valid is one cycle", {31'b0, rsp_valid}, 32'h0);

      // snapshot of every word, R6 error only on the write-only word
      for (int i = 0; i < NREG; i++) begin
         if (i == 30) continue;
         xfer(0, 12'(i * 4), 0, rd, er, rv);
         snap[i] = rd;
         chk($sformatf("R6 read error flag idx %0d", i), {31'b0, er}, {31'b0, (i == 48)});
      end

      // R3: locked sweep of the protected zone
      for (int i = 1; i < 64; i++) begin
         xfer(1, 12'(i * 4), ~snap[i] ^ 32'(i), rd, er, rv);
         chk($sformatf("R3 locked write error idx %0d", i), {31'b0, er}, 32'h1);
         chk($sformatf("R3 locked write no valid idx %0d", i), {31'b0, rv}, 32'h0);
         if (i == 30) continue;
         xfer(0, 12'(i * 4), 0, rd, er, rv);
         chk($sformatf("R3 locked word unchanged idx %0d", i), rd, snap[i]);
      end
      @(negedge clk);
      chk("R9 error pulse single cycle", {31'b0, err_pulse}, 32'h0);

      // R3 / R10: upper words accept writes while locked
      for (int i = 64; i < NREG; i++) begin
         xfer(1, 12'(i * 4), pat(i), rd, er, rv);
         chk($sformatf("R3 upper write no error idx %0d", i), {31'b0, er}, 32'h0);
         xfer(0, 12'(i * 4), 0, rd, er, rv);
         chk($sformatf("R10 upper readback idx %0d", i), rd, pat(i));
      end

      // R2: key handling
      xfer(1, 12'h000, KEY_VAL ^ 32'h1, rd, er, rv);
      xfer(0, 12'h000, 0, rd, er, rv); chk("R2 wrong key stores 0", rd, 32'h0);
      xfer(1, 12'h000, KEY_VAL, rd, er, rv);
      chk("R2 key write no error", {31'b0, er}, 32'h0);
      xfer(0, 12'h000, 0, rd, er, rv); chk("R2 right key stores 1", rd, 32'h1);

      // R4 / R6 / R10: unlocked sweep
      for (int i = 1; i < 64; i++) begin
         xfer(1, 12'(i * 4), pat(i), rd, er, rv);
         chk($sformatf("R4 write error idx %0d", i), {31'b0, er}, {31'b0, is_ro(i)});
         if (i == 30) continue;
         xfer(0, 12'(i * 4), 0, rd, er, rv);
         chk($sformatf("R10 unlocked readback idx %0d", i), rd, is_ro(i) ? snap[i] : pat(i));
         if (i == 48) chk("R6 write-only read flags error with data", {31'b0, er}, 32'h1);
      end

      // R7: beyond the map
      xfer(1, 12'h1A8, 32'hDEADBEEF, rd, er, rv); chk("R7 oob write error", {31'b0, er}, 32'h1);
      xfer(0, 12'h1A8, 0, rd, er, rv); chk("R7 oob read zero", rd, 32'h0);
      chk("R7 oob read error", {31'b0, er}, 32'h1);
      xfer(1, 12'hFFC, 32'h12345678, rd, er, rv);
      xfer(0, 12'hFFC, 0, rd, er, rv); chk("R7 top of window zero", rd, 32'h0);

      // R1: misaligned accesses
      xfer(1, 12'h042, 32'h0BADF00D, rd, er, rv); chk("R1 misaligned write error", {31'b0, er}, 32'h1);
      xfer(0, 12'h040, 0, rd, er, rv); chk("R1 aligned word untouched", rd, pat(16));
      xfer(0, 12'h041, 0, rd, er, rv); chk("R1 misaligned read zero", rd, 32'h0);
      chk("R1 misaligned read error", {31'b0, er}, 32'h1);

      // R5: random word with enable cleared and then set
      for (int pass = 0; pass < 2; pass++) begin
         xfer(1, 12'h074, 32'(pass), rd, er, rv);
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h078;
         @(negedge clk);
         r1 = rsp_rdata;
         chk("R5 rng read no error", {31'b0, err_pulse}, 32'h0);
         @(negedge clk);
         r2 = rsp_rdata;
         req_valid = 1'b0;
         chk($sformatf("R5 consecutive reads follow lfsr step pass %0d", pass), r2, lfsr_step(r1));
         chk("R5 successive reads differ", {31'b0, (r1 != r2)}, 32'h1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule